// File: doc/BRIEF.md
# Phase-based sensor power sequencer

This block steps each frame of a global-shutter pixel-array sensor through four operating phases: idle, exposure, conversion and off-chip send. It drives the power enables of the peripheral circuits so that each group is on only in the phase that uses it. The reference generator, ramp generator, PLL and ADC digital logic share one conversion window per frame. Inside that window every pixel converts at once. Outside it these circuits are off. The serializer enable covers only the send phase.

A frame starts only on an external trigger, so the frame rate is set by the host and can differ from frame to frame. At the trigger the exposure length, conversion length, settle delay and row-selection settings are captured. They then stay fixed until the frame ends.

Each powered phase opens with a settle interval before its circuits are used. The conversion phase ends with a strobe window. The send phase ends with a scan over every row index, which raises a row enable only on the rows that the window and subsample settings select. A trigger that arrives during a frame is reported and otherwise dropped. The sequencer waits for the host's readout-done handshake before it turns the serializer off and returns to idle.

Top module: `sensor_phase_seq`

## Requirements
- R1: `phase_o` encodes idle=0, exposure=1, conversion=2, send=3 and moves only in the order 0,1,2,3,0. A trigger sampled high while idle gives `phase_o`=1 in the next cycle. Without a trigger the block stays idle, and `readout_done_i` has no effect while idle.
- R2: The exposure phase lasts exactly `exp_len_i`+1 cycles.
- R3: `ref_en_o`, `ramp_en_o`, `pll_en_o` and `adc_dig_en_o` are high exactly in the cycles where `phase_o`=2. `ser_en_o` is high exactly in the cycles where `phase_o`=3. The two groups are never high together.
- R4: The conversion phase lasts `wake_len_i`+`adc_len_i`+2 cycles. Its first `wake_len_i`+1 cycles are settle cycles. `conv_go_o` is high in the remaining `adc_len_i`+1 cycles and in no other cycle.
- R5: The send phase opens with `wake_len_i`+1 settle cycles in which `row_en_o` stays low. A scan of ROWS cycles follows, in which `row_idx_o` runs 0,1,...,ROWS-1 in ascending order.
- R6: During the scan, `row_en_o` is high for row r only if the row is selected. With `roi_en_i`=1, r must lie in `roi_first_i`..`roi_last_i` inclusive; an inverted range selects no row. With `sub_en_i`=1, bit 0 of r must be 0. When both are set, both conditions must hold.
- R7: Length and row-selection inputs are captured in the trigger cycle. Changing them later in the frame does not change that frame's timing or selected rows.
- R8: A trigger sampled high while `phase_o`≠0 raises `overrun_o` in the next cycle and leaves the running frame unchanged. At all other times `overrun_o` is low.
- R9: `readout_done_i` is ignored during send settle and scan. After the scan it is awaited. When it is sampled high, `phase_o` becomes 0 and `ser_en_o` drops in the next cycle.
- R10: Out of reset, `phase_o`=0 and all enables, `conv_go_o`, `row_en_o` and `overrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| trig_i | input | 1 | Frame start request |
| exp_len_i | input | EXP_W | Exposure length minus one, in cycles |
| adc_len_i | input | ADC_W | Conversion strobe length minus one |
| wake_len_i | input | WAKE_W | Settle delay minus one, used in conversion and send |
| roi_en_i | input | 1 | Row window selection on |
| roi_first_i | input | ROW_W | First row of the window |
| roi_last_i | input | ROW_W | Last row of the window |
| sub_en_i | input | 1 | Keep even rows only |
| readout_done_i | input | 1 | Host has finished taking the frame data |
| phase_o | output | 2 | Current phase code |
| ref_en_o | output | 1 | Reference generator enable |
| ramp_en_o | output | 1 | Ramp generator enable |
| pll_en_o | output | 1 | PLL enable |
| adc_dig_en_o | output | 1 | ADC digital logic enable |
| conv_go_o | output | 1 | Conversion strobe window |
| ser_en_o | output | 1 | Serializer enable |
| row_en_o | output | 1 | Readout enable for the row on row_idx_o |
| row_idx_o | output | ROW_W | Row index during the scan |
| overrun_o | output | 1 | Trigger was dropped in the previous cycle |

## Verification
The trigger and the readout-done handshake can land in the same cycle at the end of the send phase. In that case the sequencer must close the frame and report the trigger as an overrun, not start a new frame. The bench drives both inputs high in the last wait cycle. It then requires idle, a low serializer enable and a raised overrun flag in the next cycle. A trigger in the first exposure cycle and a readout-done pulse during send settle are also injected. The exposure length and send length measured afterwards must match values computed from the captured settings.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXPOSE,
    ST_CV_SETTLE,
    ST_CV_RUN,
    ST_SD_SETTLE,
    ST_SD_SCAN,
    ST_SD_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_EXPOSE  = 2'd1,
    PH_CONVERT = 2'd2,
    PH_SEND    = 2'd3
  } phase_e;

  localparam int N_ANA = 4;

  function automatic phase_e phase_of(seq_state_e s);
    case (s)
      ST_EXPOSE:                       return PH_EXPOSE;
      ST_CV_SETTLE, ST_CV_RUN:         return PH_CONVERT;
      ST_SD_SETTLE, ST_SD_SCAN,
      ST_SD_WAIT:                      return PH_SEND;
      default:                         return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/sps_down_cnt.sv
module sps_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (dec_i && (cnt_q != '0))
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R2
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/sps_row_gate.sv
module sps_row_gate #(
  parameter int ROWS  = 16,
  parameter int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load_i,
  input  logic             roi_en_i,
  input  logic [ROW_W-1:0] roi_first_i,
  input  logic [ROW_W-1:0] roi_last_i,
  input  logic             sub_en_i,
  input  logic             scan_clr_i,
  input  logic             scan_step_i,
  output logic [ROW_W-1:0] row_idx_o,
  output logic             row_last_o,
  output logic             row_sel_o
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic             roi_q;
  logic             sub_q;
  logic [ROW_W-1:0] first_q;
  logic [ROW_W-1:0] last_q;
  logic [ROW_W-1:0] row_q, row_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      roi_q   <= 1'b0;
      sub_q   <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
    end else if (cfg_load_i) begin
      roi_q   <= roi_en_i;
      sub_q   <= sub_en_i;
      first_q <= roi_first_i;
      last_q  <= roi_last_i;
    end
  end

  always_comb begin
    row_d = row_q;
    if (scan_clr_i)
      row_d = '0;
    else if (scan_step_i && (row_q != LAST_ROW))
      row_d = row_q + ROW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      row_q <= '0;
    else
      row_q <= row_d;
  end

  logic in_window;
  logic keep_sub;

  assign in_window  = !roi_q || ((row_q >= first_q) && (row_q <= last_q));
  assign keep_sub   = !sub_q || !row_q[0];
  assign row_sel_o  = in_window && keep_sub;
  assign row_idx_o  = row_q;
  assign row_last_o = (row_q == LAST_ROW);

  // R5
  row_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_step_i && !scan_clr_i && !row_last_o) |=> (row_idx_o != '0));

endmodule

// File: rtl/sps_power_map.sv
module sps_power_map
  import sps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           nxt_phase_i,
  output logic [N_ANA-1:0] ana_en_o,
  output logic             ser_en_o
);

  logic [N_ANA-1:0] ana_q;
  logic             ser_q;

  for (genvar g = 0; g < N_ANA; g++) begin : g_ana
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ana_q[g] <= 1'b0;
      else
        ana_q[g] <= (nxt_phase_i == PH_CONVERT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ser_q <= 1'b0;
    else
      ser_q <= (nxt_phase_i == PH_SEND);
  end

  assign ana_en_o = ana_q;
  assign ser_en_o = ser_q;

  // R3
  ana_group_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ana_q) |-> !ser_q);

endmodule

// File: rtl/sensor_phase_seq.sv
module sensor_phase_seq
  import sps_pkg::*;
#(
  parameter int EXP_W  = 10,
  parameter int ADC_W  = 8,
  parameter int WAKE_W = 6,
  parameter int ROWS   = 16,
  parameter int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [EXP_W-1:0]  exp_len_i,
  input  logic [ADC_W-1:0]  adc_len_i,
  input  logic [WAKE_W-1:0] wake_len_i,
  input  logic              roi_en_i,
  input  logic [ROW_W-1:0]  roi_first_i,
  input  logic [ROW_W-1:0]  roi_last_i,
  input  logic              sub_en_i,
  input  logic              readout_done_i,
  output logic [1:0]        phase_o,
  output logic              ref_en_o,
  output logic              ramp_en_o,
  output logic              pll_en_o,
  output logic              adc_dig_en_o,
  output logic              conv_go_o,
  output logic              ser_en_o,
  output logic              row_en_o,
  output logic [ROW_W-1:0]  row_idx_o,
  output logic              overrun_o
);

  localparam int AW_MAX = (ADC_W > WAKE_W) ? ADC_W : WAKE_W;
  localparam int CNT_W  = (EXP_W > AW_MAX) ? EXP_W : AW_MAX;

  seq_state_e state_q, state_d;

  logic [ADC_W-1:0]  adc_q;
  logic [WAKE_W-1:0] wake_q;
  logic              overrun_q;

  logic             cfg_load;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_dec;
  logic             cnt_zero;
  logic             scan_clr;
  logic             scan_step;
  logic             row_last;
  logic             row_sel;
  logic [N_ANA-1:0] ana_en;

  // next-state process
  always_comb begin
    state_d   = state_q;
    cfg_load  = 1'b0;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    cnt_dec   = 1'b0;
    scan_clr  = 1'b0;
    scan_step = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          state_d  = ST_EXPOSE;
          cfg_load = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(exp_len_i);
        end
      end
      ST_EXPOSE: begin
        if (cnt_zero) begin
          state_d  = ST_CV_SETTLE;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(wake_q);
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_CV_SETTLE: begin
        if (cnt_zero) begin
          state_d  = ST_CV_RUN;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(adc_q);
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_CV_RUN: begin
        if (cnt_zero) begin
          state_d  = ST_SD_SETTLE;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(wake_q);
          scan_clr = 1'b1;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_SD_SETTLE: begin
        if (cnt_zero)
          state_d = ST_SD_SCAN;
        else
          cnt_dec = 1'b1;
      end
      ST_SD_SCAN: begin
        scan_step = 1'b1;
        if (row_last)
          state_d = ST_SD_WAIT;
      end
      ST_SD_WAIT: begin
        if (readout_done_i)
          state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      overrun_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      overrun_q <= trig_i && (state_q != ST_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_q  <= '0;
      wake_q <= '0;
    end else if (cfg_load) begin
      adc_q  <= adc_len_i;
      wake_q <= wake_len_i;
    end
  end

  sps_down_cnt #(.W(CNT_W)) u_len_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero)
  );

  sps_row_gate #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load_i  (cfg_load),
    .roi_en_i    (roi_en_i),
    .roi_first_i (roi_first_i),
    .roi_last_i  (roi_last_i),
    .sub_en_i    (sub_en_i),
    .scan_clr_i  (scan_clr),
    .scan_step_i (scan_step),
    .row_idx_o   (row_idx_o),
    .row_last_o  (row_last),
    .row_sel_o   (row_sel)
  );

  sps_power_map u_power_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .nxt_phase_i (phase_of(state_d)),
    .ana_en_o    (ana_en),
    .ser_en_o    (ser_en_o)
  );

  assign phase_o      = phase_of(state_q);
  assign ref_en_o     = ana_en[0];
  assign ramp_en_o    = ana_en[1];
  assign pll_en_o     = ana_en[2];
  assign adc_dig_en_o = ana_en[3];
  assign conv_go_o    = (state_q == ST_CV_RUN);
  assign row_en_o     = (state_q == ST_SD_SCAN) && row_sel;
  assign overrun_o    = overrun_q;

  // R1
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |-> (phase_o == 2'($past(phase_o) + 2'd1)));

  // R3
  ana_in_convert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_en_o || ramp_en_o || pll_en_o || adc_dig_en_o) |-> (phase_o == PH_CONVERT));

  // R3
  ser_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en_o |-> (phase_o == PH_SEND));

  // R4
  settle_before_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_go_o) |-> $past(ref_en_o));

  // R8
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && (phase_o != PH_IDLE)) |=> overrun_o);

  // R8
  overrun_keeps_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && (phase_o == PH_EXPOSE)) |=> (phase_o != PH_IDLE));

  // R9
  early_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_done_i && ((state_q == ST_SD_SETTLE) || (state_q == ST_SD_SCAN)))
      |=> (ser_en_o && (phase_o == PH_SEND)));

  // R9
  done_closes_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_done_i && (state_q == ST_SD_WAIT)) |=> (!ser_en_o && (phase_o == PH_IDLE)));

  // R6
  row_en_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_en_o |-> ser_en_o);

endmodule

// File: tb/sensor_phase_seq_bench.sv
`timescale 1ns/1ps
module sensor_phase_seq_bench;

  localparam int EXP_W  = 10;
  localparam int ADC_W  = 8;
  localparam int WAKE_W = 6;
  localparam int ROWS   = 16;
  localparam int ROW_W  = 4;

  logic              clk;
  logic              rst_n;
  logic              trig_i;
  logic [EXP_W-1:0]  exp_len_i;
  logic [ADC_W-1:0]  adc_len_i;
  logic [WAKE_W-1:0] wake_len_i;
  logic              roi_en_i;
  logic [ROW_W-1:0]  roi_first_i;
  logic [ROW_W-1:0]  roi_last_i;
  logic              sub_en_i;
  logic              readout_done_i;
  logic [1:0]        phase_o;
  logic              ref_en_o, ramp_en_o, pll_en_o, adc_dig_en_o;
  logic              conv_go_o, ser_en_o, row_en_o, overrun_o;
  logic [ROW_W-1:0]  row_idx_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_all = 0;

  sensor_phase_seq #(
    .EXP_W(EXP_W), .ADC_W(ADC_W), .WAKE_W(WAKE_W), .ROWS(ROWS), .ROW_W(ROW_W)
  ) u_sensor_phase_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .exp_len_i(exp_len_i),
    .adc_len_i(adc_len_i), .wake_len_i(wake_len_i), .roi_en_i(roi_en_i),
    .roi_first_i(roi_first_i), .roi_last_i(roi_last_i), .sub_en_i(sub_en_i),
    .readout_done_i(readout_done_i), .phase_o(phase_o), .ref_en_o(ref_en_o),
    .ramp_en_o(ramp_en_o), .pll_en_o(pll_en_o), .adc_dig_en_o(adc_dig_en_o),
    .conv_go_o(conv_go_o), .ser_en_o(ser_en_o), .row_en_o(row_en_o),
    .row_idx_o(row_idx_o), .overrun_o(overrun_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  function automatic bit row_wanted(int r, bit roi, int f, int l, bit sub);
    bit win  = !roi || (r >= f && r <= l);
    bit keep = !sub || (r % 2 == 0);
    return win && keep;
  endfunction

  function automatic int rows_expected(bit roi, int f, int l, bit sub);
    int n = 0;
    for (int r = 0; r < ROWS; r++)
      if (row_wanted(r, roi, f, l, sub)) n++;
    return n;
  endfunction

  task automatic run_frame(input int e, input int a, input int w, input bit roi,
                           input int f, input int l, input bit sub, input int dd,
                           input bit mid, input bit early, input bit coinc);
    int n_exp = 0, n_cv = 0, n_go = 0, first_go = 0, n_send = 0;
    int n_rows = 0, last_row = -1, en_err = 0, ov_err = 0, row_err = 0;
    int ov_seen = 0, guard = 0, ph = 0, first_ph = -1;
    bit ov_exp = 0, fin = 0;
    @(negedge clk);
    exp_len_i   = EXP_W'(e);
    adc_len_i   = ADC_W'(a);
    wake_len_i  = WAKE_W'(w);
    roi_en_i    = roi;
    roi_first_i = ROW_W'(f);
    roi_last_i  = ROW_W'(l);
    sub_en_i    = sub;
    trig_i      = 1'b1;
    @(negedge clk);
    trig_i      = 1'b0;
    // R7: scramble the configuration once the frame has captured it
    exp_len_i   = EXP_W'($urandom);
    adc_len_i   = ADC_W'($urandom);
    wake_len_i  = WAKE_W'($urandom);
    roi_en_i    = ~roi;
    roi_first_i = ROW_W'($urandom);
    roi_last_i  = ROW_W'($urandom);
    sub_en_i    = ~sub;
    while (!fin && guard < 5000) begin
      guard++;
      ph = int'(phase_o);
      if (first_ph < 0) first_ph = ph;
      if ((ref_en_o != (ph == 2)) || (ramp_en_o != (ph == 2)) ||
          (pll_en_o != (ph == 2)) || (adc_dig_en_o != (ph == 2)) ||
          (ser_en_o != (ph == 3)) || (conv_go_o && ph != 2)) en_err++;
      if (overrun_o != ov_exp) ov_err++;
      if (overrun_o) ov_seen++;
      trig_i = 1'b0;
      readout_done_i = 1'b0;
      case (ph)
        1: n_exp++;
        2: begin
          n_cv++;
          if (conv_go_o) begin
            n_go++;
            if (first_go == 0) first_go = n_cv;
          end
        end
        3: n_send++;
        default: fin = 1;
      endcase
      if (row_en_o) begin
        if (ph != 3) row_err++;
        else begin
          n_rows++;
          if (!row_wanted(int'(row_idx_o), roi, f, l, sub) || int'(row_idx_o) <= last_row)
            row_err++;
          last_row = int'(row_idx_o);
        end
      end
      if (ph == 3 && n_send <= w + 1 && row_en_o) row_err++;
      if (ph == 3 && n_send > w + 1 && n_send <= w + 1 + ROWS &&
          int'(row_idx_o) != n_send - w - 2) row_err++;
      if (mid && ph == 1 && n_exp == 1) trig_i = 1'b1;
      if (early && ph == 3 && n_send == 1) readout_done_i = 1'b1;
      if (ph == 3 && n_send == w + ROWS + 2 + dd) begin
        readout_done_i = 1'b1;
        if (coinc) trig_i = 1'b1;
      end
      ov_exp = trig_i && (ph != 0);
      if (!fin) @(negedge clk);
    end
    trig_i = 1'b0;
    readout_done_i = 1'b0;
    check(first_ph == 1, "R1", "phase after trigger", first_ph, 1);
    check(guard < 5000, "R9", "frame returned to idle", guard, 0);
    check(n_exp == e + 1, "R2 R7", "exposure cycles", n_exp, e + 1);
    check(en_err == 0, "R3", "enable/phase mismatches", en_err, 0);
    check(n_cv == w + a + 2, "R4", "conversion cycles", n_cv, w + a + 2);
    check(n_go == a + 1 && first_go == w + 2, "R4", "strobe start cycle",
          first_go, w + 2);
    check(row_err == 0, "R5 R6", "row scan errors", row_err, 0);
    check(n_rows == rows_expected(roi, f, l, sub), "R6 R7", "rows enabled",
          n_rows, rows_expected(roi, f, l, sub));
    check(n_send == w + ROWS + 2 + dd, "R9", "send cycles", n_send, w + ROWS + 2 + dd);
    check(ov_err == 0 && ov_seen == int'(mid) + int'(coinc), "R8", "overrun pulses",
          ov_seen, int'(mid) + int'(coinc));
  endtask

  initial begin
    int seed_v;
    int bad;
    seed_v = $urandom(32'h5EC0_0A11);
    rst_n = 1'b0;
    trig_i = 1'b0; exp_len_i = '0; adc_len_i = '0; wake_len_i = '0;
    roi_en_i = 1'b0; roi_first_i = '0; roi_last_i = '0; sub_en_i = 1'b0;
    readout_done_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    check(phase_o == 2'd0 && !ref_en_o && !ramp_en_o && !pll_en_o && !adc_dig_en_o &&
          !ser_en_o && !conv_go_o && !row_en_o && !overrun_o, "R10", "reset outputs",
          int'(phase_o), 0);
    // R1: idle without trigger, done pulses ignored
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      readout_done_i = i[0];
      @(negedge clk);
      if (phase_o != 2'd0 || ser_en_o || overrun_o) bad++;
    end
    readout_done_i = 1'b0;
    check(bad == 0, "R1", "idle held without trigger", bad, 0);

    run_frame(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_frame(5, 3, 2, 1, 3, 9, 0, 2, 1, 1, 0);
    run_frame(7, 4, 1, 1, 12, 4, 0, 0, 0, 0, 1);
    run_frame(2, 1, 3, 0, 0, 0, 1, 1, 1, 0, 1);
    run_frame(1, 2, 0, 1, 2, 13, 1, 3, 0, 1, 0);
    run_frame(0, 0, 0, 1, 15, 15, 0, 0, 1, 1, 1);
    for (int k = 0; k < 20; k++)
      run_frame(int'($urandom_range(0, 40)), int'($urandom_range(0, 30)),
                int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)),
                int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                bit'($urandom_range(0, 1)), int'($urandom_range(0, 4)),
                bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                bit'($urandom_range(0, 1)));
    if (!done_all) begin
      done_all = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done_all) begin
      done_all = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule